// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block sorts every fault reported against a small processor core into a response: pend a BusFault, pend a MemManage fault, pend a HardFault, or freeze the core in a lockup state. Load faults on the bus and all memory-protection faults are synchronous and take effect at once. Bus store faults come back later from the write path, so they are asynchronous. Faults raised by debugger accesses are only reported back to the debug side.

Each class of fault sets bits in its own status register. A synchronous BusFault or MemManage fault also latches the faulting address, unless an earlier address is still marked valid. Software clears any status bit by writing a 1 to it. While the block is in lockup it holds instruction issue stalled. The way out of lockup depends on which handler was running when the core locked up.

Top module: `fault_esc_top`

## Requirements
- R1: A debugger fault (`faultFromDbg`=1) raises `dbgFault` for one cycle on the next edge. It pends no exception, changes no status register and has no effect on lockup.
- R2: A processor bus store fault (`faultIsMem`=0, `faultIsStore`=1) is asynchronous and sets `busStat` bit 1 (imprecise). It pends BusFault if `busEn`=1. If `busEn`=0 it pends HardFault and sets `hardStat` bit 1 (asynchronous escalation). It leaves `busAddr` and `busStat` bit 2 unchanged.
- R3: An asynchronous bus fault never causes lockup, whatever the value of `ctxMode`.
- R4: A synchronous fault (bus load, or any memory-protection fault) raised with `ctxMode` 0 (thread) or 1 (configurable handler) pends its own handler when that handler is enabled. A bus fault sets `busStat` bit 0 and a memory-protection fault sets `memStat` bit 0. No more than one pend strobe is high in any cycle.
- R5: When the target handler of such a synchronous fault is disabled, the fault pends HardFault and sets `hardStat` bit 0 (forced escalation).
- R6: A synchronous fault raised with `ctxMode` 2 (HardFault handler) or 3 (NMI handler) sets `lockup` on the next edge. It pends nothing, but its status and address are still recorded.
- R7: While in lockup, `dbgHaltReq` clears `lockup` on the next edge. `nmiReq` also clears it, but only if lockup was entered from `ctxMode` 2.
- R8: If lockup was entered from `ctxMode` 3, `nmiReq` leaves `lockup` set. Only reset or `dbgHaltReq` releases it.
- R9: A synchronous bus or memory-protection fault loads `busAddr` or `memAddr` and sets the valid bit (`busStat` bit 2, `memStat` bit 1) only when that valid bit was clear. While the valid bit stays set, the address is held.
- R10: A 1 in a bit of `busClr`, `memClr` or `hardClr` clears the matching status bit on the next edge. If a set and a clear of the same bit arrive in one cycle, the set wins.
- R11: After reset, all pend strobes, `dbgFault`, `lockup`, every status bit and both address registers are zero.
- R12: While `lockup` is set, processor faults pend no exception and set no `hardStat` bit. BusFault and MemManage status bits are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| faultValid | input | 1 | A fault is reported this cycle |
| faultIsMem | input | 1 | 1: memory-protection fault, 0: bus fault |
| faultIsStore | input | 1 | 1: faulting access was a store |
| faultFromDbg | input | 1 | 1: access issued by the debugger |
| faultAddr | input | ADDR_W | Address of the faulting access |
| ctxMode | input | 2 | 0 thread, 1 configurable handler, 2 HardFault handler, 3 NMI handler |
| busEn | input | 1 | BusFault handler enabled |
| memEn | input | 1 | MemManage handler enabled |
| nmiReq | input | 1 | NMI request |
| dbgHaltReq | input | 1 | Debugger halt request |
| busClr | input | 3 | Write-1-to-clear mask for busStat |
| memClr | input | 2 | Write-1-to-clear mask for memStat |
| hardClr | input | 2 | Write-1-to-clear mask for hardStat |
| pendBus | output | 1 | Pend BusFault strobe |
| pendMem | output | 1 | Pend MemManage strobe |
| pendHard | output | 1 | Pend HardFault strobe |
| dbgFault | output | 1 | Fault reported to the debug side |
| lockup | output | 1 | Core locked up, instruction issue stalled |
| busStat | output | 3 | {addrValid, imprecise, precise} |
| memStat | output | 2 | {addrValid, violation} |
| hardStat | output | 2 | {asyncEscalated, forced} |
| busAddr | output | ADDR_W | Captured bus fault address |
| memAddr | output | ADDR_W | Captured memory-protection fault address |

## Verification
The bench builds the block with `ADDR_W` set to 16. At that width, distinct fault addresses make a held address plainly different from a later one, which makes the hold rule visible. The same sequence steps through every `ctxMode` against both store and load faults, with each handler enable on and off. It then enters lockup once from the HardFault context and once from the NMI context, so that the two NMI exit rules can be compared directly.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  typedef enum logic [1:0] {
    CTX_THREAD = 2'd0,
    CTX_CFG    = 2'd1,
    CTX_HARD   = 2'd2,
    CTX_NMI    = 2'd3
  } ctx_e;

  typedef struct packed {
    logic setBusPrec;
    logic setBusImp;
    logic setMem;
    logic setForced;
    logic setAsyncHard;
  } recStrb_t;
endpackage

// File: rtl/fault_esc_ctl.sv
module fault_esc_ctl
  import fault_esc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultValid,
  input  logic       faultIsMem,
  input  logic       faultIsStore,
  input  logic       faultFromDbg,
  input  logic [1:0] ctxMode,
  input  logic       busEn,
  input  logic       memEn,
  input  logic       nmiReq,
  input  logic       dbgHaltReq,
  output recStrb_t   strb,
  output logic       pendBus,
  output logic       pendMem,
  output logic       pendHard,
  output logic       dbgFault,
  output logic       lockup
);
  logic isAsync, isSync, inCrit, tgtEn, goLock, lockFromNmi;
  logic nxtPendBus, nxtPendMem, nxtPendHard;

  always_comb begin
    isAsync = faultValid & ~faultFromDbg & ~faultIsMem & faultIsStore;
    isSync  = faultValid & ~faultFromDbg & ~isAsync;
    inCrit  = (ctxMode == CTX_HARD) || (ctxMode == CTX_NMI);
    tgtEn   = faultIsMem ? memEn : busEn;
    goLock  = isSync & inCrit & ~lockup;

    strb.setBusPrec   = isSync & ~faultIsMem;
    strb.setMem       = isSync & faultIsMem;
    strb.setBusImp    = isAsync;
    strb.setAsyncHard = isAsync & ~busEn & ~lockup;
    strb.setForced    = isSync & ~inCrit & ~tgtEn & ~lockup;

    nxtPendBus  = ~lockup & ((isAsync & busEn) | (isSync & ~inCrit & ~faultIsMem & busEn));
    nxtPendMem  = ~lockup & isSync & ~inCrit & faultIsMem & memEn;
    nxtPendHard = ~lockup & ((isAsync & ~busEn) | (isSync & ~inCrit & ~tgtEn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBus     <= 1'b0;
      pendMem     <= 1'b0;
      pendHard    <= 1'b0;
      dbgFault    <= 1'b0;
      lockup      <= 1'b0;
      lockFromNmi <= 1'b0;
    end else begin
      pendBus  <= nxtPendBus;
      pendMem  <= nxtPendMem;
      pendHard <= nxtPendHard;
      dbgFault <= faultValid & faultFromDbg;
      if (lockup) begin
        if (dbgHaltReq || (nmiReq && !lockFromNmi)) lockup <= 1'b0;
      end else if (goLock) begin
        lockup      <= 1'b1;
        lockFromNmi <= (ctxMode == CTX_NMI);
      end
    end
  end
endmodule

// File: rtl/fault_esc_dp.sv
module fault_esc_dp
  import fault_esc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  recStrb_t          strb,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [2:0]        busClr,
  input  logic [1:0]        memClr,
  input  logic [1:0]        hardClr,
  output logic [2:0]        busStat,
  output logic [1:0]        memStat,
  output logic [1:0]        hardStat,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] memAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busStat  <= '0;
      memStat  <= '0;
      hardStat <= '0;
      busAddr  <= '0;
      memAddr  <= '0;
    end else begin
      busStat[0]  <= strb.setBusPrec   | (busStat[0]  & ~busClr[0]);
      busStat[1]  <= strb.setBusImp    | (busStat[1]  & ~busClr[1]);
      memStat[0]  <= strb.setMem       | (memStat[0]  & ~memClr[0]);
      hardStat[0] <= strb.setForced    | (hardStat[0] & ~hardClr[0]);
      hardStat[1] <= strb.setAsyncHard | (hardStat[1] & ~hardClr[1]);

      if (strb.setBusPrec && !busStat[2]) begin
        busStat[2] <= 1'b1;
        busAddr    <= faultAddr;
      end else if (busClr[2]) begin
        busStat[2] <= 1'b0;
      end

      if (strb.setMem && !memStat[1]) begin
        memStat[1] <= 1'b1;
        memAddr    <= faultAddr;
      end else if (memClr[1]) begin
        memStat[1] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fault_esc_top.sv
module fault_esc_top
  import fault_esc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic              faultIsMem,
  input  logic              faultIsStore,
  input  logic              faultFromDbg,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [1:0]        ctxMode,
  input  logic              busEn,
  input  logic              memEn,
  input  logic              nmiReq,
  input  logic              dbgHaltReq,
  input  logic [2:0]        busClr,
  input  logic [1:0]        memClr,
  input  logic [1:0]        hardClr,
  output logic              pendBus,
  output logic              pendMem,
  output logic              pendHard,
  output logic              dbgFault,
  output logic              lockup,
  output logic [2:0]        busStat,
  output logic [1:0]        memStat,
  output logic [1:0]        hardStat,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] memAddr
);
  recStrb_t strb;

  fault_esc_ctl uCtl (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultIsMem(faultIsMem),
    .faultIsStore(faultIsStore), .faultFromDbg(faultFromDbg), .ctxMode(ctxMode),
    .busEn(busEn), .memEn(memEn), .nmiReq(nmiReq), .dbgHaltReq(dbgHaltReq),
    .strb(strb), .pendBus(pendBus), .pendMem(pendMem), .pendHard(pendHard),
    .dbgFault(dbgFault), .lockup(lockup)
  );

  fault_esc_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .faultAddr(faultAddr),
    .busClr(busClr), .memClr(memClr), .hardClr(hardClr),
    .busStat(busStat), .memStat(memStat), .hardStat(hardStat),
    .busAddr(busAddr), .memAddr(memAddr)
  );
endmodule

// File: rtl/fault_esc_chk.sv
module fault_esc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic              faultIsMem,
  input logic              faultIsStore,
  input logic              faultFromDbg,
  input logic [1:0]        ctxMode,
  input logic [2:0]        busClr,
  input logic              pendBus,
  input logic              pendMem,
  input logic              pendHard,
  input logic              dbgFault,
  input logic              lockup,
  input logic [2:0]        busStat,
  input logic [ADDR_W-1:0] busAddr
);
  AST_DBG_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    dbgFault |-> !(pendBus || pendMem || pendHard)); // R1

  AST_ASYNC_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultFromDbg && !faultIsMem && faultIsStore && !lockup) |=> !lockup); // R3

  AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pendBus, pendMem, pendHard})); // R4

  AST_SYNC_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultFromDbg && (faultIsMem || !faultIsStore) && ctxMode[1] && !lockup)
      |=> lockup); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busStat[2] && !busClr[2]) |=> (busStat[2] && $stable(busAddr))); // R9

  AST_LOCK_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    lockup |-> !(pendBus || pendMem || pendHard)); // R12
endmodule

bind fault_esc_top fault_esc_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultIsMem(faultIsMem),
  .faultIsStore(faultIsStore), .faultFromDbg(faultFromDbg), .ctxMode(ctxMode),
  .busClr(busClr), .pendBus(pendBus), .pendMem(pendMem), .pendHard(pendHard),
  .dbgFault(dbgFault), .lockup(lockup), .busStat(busStat), .busAddr(busAddr)
);

// File: tb/sim_fault_esc_top.sv
module sim_fault_esc_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultValid = 0, faultIsMem = 0, faultIsStore = 0, faultFromDbg = 0;
  logic [AW-1:0] faultAddr = '0;
  logic [1:0] ctxMode = 2'd0;
  logic busEn = 0, memEn = 0, nmiReq = 0, dbgHaltReq = 0;
  logic [2:0] busClr = '0;
  logic [1:0] memClr = '0, hardClr = '0;
  logic pendBus, pendMem, pendHard, dbgFault, lockup;
  logic [2:0] busStat;
  logic [1:0] memStat, hardStat;
  logic [AW-1:0] busAddr, memAddr;

  fault_esc_top #(.ADDR_W(AW)) u0 (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  string curReq = "R11";

  // behavioural reference state
  bit mPB, mPM, mPH, mDbg, mLock, mLockNmi;
  bit [2:0] mBS;
  bit [1:0] mMS, mHS;
  bit [AW-1:0] mBA, mMA;
  bit asyn, sync, crit, hEn, oldBV, oldMV;

  always @(posedge clk) begin
    if (!rstN) begin
      {mPB, mPM, mPH, mDbg, mLock, mLockNmi} = '0;
      mBS = '0; mMS = '0; mHS = '0; mBA = '0; mMA = '0;
    end else begin
      asyn = faultValid && !faultFromDbg && !faultIsMem && faultIsStore;
      sync = faultValid && !faultFromDbg && !asyn;
      crit = (ctxMode >= 2);
      hEn  = faultIsMem ? memEn : busEn;
      oldBV = mBS[2]; oldMV = mMS[1];
      mDbg = faultValid && faultFromDbg;
      mPB = 0; mPM = 0; mPH = 0;
      for (int i = 0; i < 3; i++) if (busClr[i]) mBS[i] = 0;
      for (int i = 0; i < 2; i++) begin
        if (memClr[i]) mMS[i] = 0;
        if (hardClr[i]) mHS[i] = 0;
      end
      if (asyn) begin
        mBS[1] = 1;
        if (!mLock) begin
          if (busEn) mPB = 1; else begin mPH = 1; mHS[1] = 1; end
        end
      end
      if (sync) begin
        if (faultIsMem) begin
          mMS[0] = 1;
          if (!oldMV) begin mMS[1] = 1; mMA = faultAddr; end
        end else begin
          mBS[0] = 1;
          if (!oldBV) begin mBS[2] = 1; mBA = faultAddr; end
        end
        if (!mLock && !crit) begin
          if (!hEn) begin mPH = 1; mHS[0] = 1; end
          else if (faultIsMem) mPM = 1;
          else mPB = 1;
        end
      end
      if (mLock) begin
        if (dbgHaltReq || (nmiReq && !mLockNmi)) mLock = 0;
      end else if (sync && crit) begin
        mLock = 1; mLockNmi = (ctxMode == 2'd3);
      end
    end
  end

  task automatic cmp(string nm, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cmp("pends", {pendBus, pendMem, pendHard}, {mPB, mPM, mPH});
      cmp("dbgFault", dbgFault, mDbg);
      cmp("lockup", lockup, mLock);
      cmp("busStat", busStat, mBS);
      cmp("memStat", memStat, mMS);
      cmp("hardStat", hardStat, mHS);
      cmp("busAddr", busAddr, mBA);
      cmp("memAddr", memAddr, mMA);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    faultValid = 0; nmiReq = 0; dbgHaltReq = 0;
    busClr = '0; memClr = '0; hardClr = '0;
  endtask

  task automatic fault(bit isMem, bit isSt, bit dbg, logic [AW-1:0] a, logic [1:0] ctx);
    faultValid = 1; faultIsMem = isMem; faultIsStore = isSt; faultFromDbg = dbg;
    faultAddr = a; ctxMode = ctx;
    step(); idle(); step();
  endtask

  bit done = 0;

  initial begin
    #1;
    repeat (3) step();
    rstN = 1;
    curReq = "R11"; step(); step();
    curReq = "R1";  busEn = 1; memEn = 1; fault(0, 0, 1, 16'h1111, 2'd0);
    fault(1, 1, 1, 16'h1112, 2'd3);
    curReq = "R2";  fault(0, 1, 0, 16'h2222, 2'd0);
    busEn = 0; fault(0, 1, 0, 16'h2223, 2'd1);
    curReq = "R3";  fault(0, 1, 0, 16'h3333, 2'd2);
    fault(0, 1, 0, 16'h3334, 2'd3);
    curReq = "R4";  busEn = 1; fault(0, 0, 0, 16'h4444, 2'd0);
    fault(1, 0, 0, 16'h4445, 2'd1);
    curReq = "R9";  fault(0, 0, 0, 16'h9999, 2'd1);
    fault(1, 1, 0, 16'h999A, 2'd0);
    curReq = "R10"; busClr = 3'b111; memClr = 2'b11; hardClr = 2'b11; step(); idle(); step();
    busClr = 3'b001; faultValid = 1; faultIsMem = 0; faultIsStore = 0; faultAddr = 16'hA0A0;
    ctxMode = 2'd0; step(); idle(); step();
    curReq = "R9";  busClr = 3'b100; step(); idle();
    fault(0, 0, 0, 16'h9ABC, 2'd0);
    curReq = "R5";  busEn = 0; memEn = 0; fault(0, 0, 0, 16'h5555, 2'd0);
    fault(1, 0, 0, 16'h5556, 2'd1);
    curReq = "R6";  busEn = 1; memEn = 1; fault(0, 0, 0, 16'h6666, 2'd2);
    curReq = "R12"; fault(0, 1, 0, 16'h6667, 2'd0);
    fault(1, 0, 0, 16'h6668, 2'd1);
    curReq = "R7";  nmiReq = 1; step(); idle(); step();
    curReq = "R6";  fault(1, 1, 0, 16'h7777, 2'd2);
    curReq = "R7";  dbgHaltReq = 1; step(); idle(); step();
    curReq = "R8";  fault(0, 0, 0, 16'h8888, 2'd3);
    nmiReq = 1; step(); idle(); step();
    nmiReq = 1; step(); idle(); step();
    dbgHaltReq = 1; step(); idle(); step();
    curReq = "R7";  nmiReq = 1; step(); idle(); step();
    curReq = "R11"; rstN = 0; step(); step(); rstN = 1; step(); step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule